// File: doc/BRIEF.md
# Streamer link statistics collector

This block gathers frame-level statistics for a packet streaming link. It takes single-cycle event pulses for frames sent, frames received, block-loss indications and frame-loss events, where a loss event carries a count of the frames lost. It also takes a per-frame latency value with a valid strobe. From these it keeps running counters, plus the minimum, maximum and 64-bit accumulated sum of the latency together with a count of samples, so that software can work out the average. It also keeps a transmit sequence number.

Software controls the block through three inputs. A statistics-clear pulse zeroes the statistics and stamps the clear with the current time reference, made of the cycle count and the low 32 bits of the TAI seconds. A separate pulse clears only the sequence number. A snapshot level freezes a coherent copy of every statistic, taken in a single cycle, while the live counters keep running underneath. When the snapshot level is low, the statistic outputs track the live values one cycle behind.

Top module: `stream_stats_top`

## Requirements
- R1: A one-cycle `stat_clr_i` pulse zeroes the sent, received, lost and block-loss counters, the latency maximum, sum and sample count, and the overflow flag. It sets the latency minimum to all ones (0x0FFFFFFF). Clear wins over any event in the same cycle.
- R2: On `stat_clr_i`, the block captures `cyc_i` (28 bits) and `tai_i[31:0]` as the clear timestamp and holds them until the next clear.
- R3: Each cycle with `tx_frame_i`, `rx_frame_i` or `blk_loss_i` high adds one to the 32-bit sent, received or block-loss counter. A cycle with the input low leaves that counter unchanged.
- R4: Each cycle with `loss_i` high adds `loss_num_i` to the 32-bit lost counter. The counter saturates at 0xFFFFFFFF.
- R5: Each latency sample (`lat_vld_i` high) updates the 28-bit maximum and minimum when it exceeds them or falls below them.
- R6: Each latency sample is added to a SUM_W-bit sum, presented as `sum_lo_o` (bits 31:0) and `sum_hi_o` (bits SUM_W-1:32, zero-extended to 32 bits). Each sample also adds one to the 32-bit sample count.
- R7: When an addition carries out of the SUM_W-bit sum, `sum_ovf_o` goes to 1 and stays at 1 until the next statistics clear.
- R8: The rising edge of `snap_i` captures every statistic output in the same cycle. While `snap_i` stays high, the outputs hold that copy and the live counters keep counting.
- R9: While `snap_i` is low, every statistic output equals the live value of the previous cycle.
- R10: `seq_o` increments on `tx_frame_i`. A `seq_clr_i` pulse zeroes it and takes priority over the increment. `stat_clr_i` does not affect `seq_o`, and `seq_clr_i` does not affect the statistics.
- R11: After `rst`, all counters, the sum, the timestamp, the flag and `seq_o` read 0, and the minimum reads 0x0FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_clr_i | input | 1 | Statistics clear pulse (timestamped) |
| seq_clr_i | input | 1 | Sequence number clear pulse |
| snap_i | input | 1 | Snapshot level; the rising edge freezes the outputs |
| tx_frame_i | input | 1 | Frame sent event |
| rx_frame_i | input | 1 | Frame received event |
| loss_i | input | 1 | Frame loss event |
| loss_num_i | input | 32 | Number of frames lost with `loss_i` |
| blk_loss_i | input | 1 | Block loss indication |
| lat_vld_i | input | 1 | Latency sample valid |
| lat_i | input | 28 | Latency sample |
| tai_i | input | 40 | TAI seconds |
| cyc_i | input | 28 | Cycle count within the second |
| seq_o | output | SEQ_W | Transmit sequence number |
| sent_o | output | 32 | Frames sent |
| rcvd_o | output | 32 | Frames received |
| lost_o | output | 32 | Frames lost (saturating) |
| blk_o | output | 32 | Block-loss indications |
| lat_max_o | output | 28 | Maximum latency |
| lat_min_o | output | 28 | Minimum latency |
| sum_lo_o | output | 32 | Latency sum, low word |
| sum_hi_o | output | 32 | Latency sum, high word |
| lat_n_o | output | 32 | Number of latency samples |
| sum_ovf_o | output | 1 | Sticky latency sum overflow |
| ts_cyc_o | output | 28 | Cycle count at the last clear |
| ts_tai_o | output | 32 | TAI low word at the last clear |

## Verification
The in-RTL assertions check the following on every cycle:
- clear results and the timestamp capture;
- that counters move only on their events and that the saturating counter never goes down;
- the min/max bounds after each sample and the sample-count step;
- that the overflow flag is sticky;
- that the frozen outputs stay stable, and that they follow the live values when not frozen;
- that the sequence number is independent of the statistics clear.

Only the bench scenarios can show the exact sums, including the carry into the high word and the sample on which the overflow flag first sets. The same holds for saturation of the lost counter at its limit and for the values a snapshot freezes against the counts that arrive while it is held.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ST_CNT_W = 32;
  localparam int ST_LAT_W = 28;
  localparam int ST_CYC_W = 28;
  localparam int ST_TAI_W = 40;
  localparam int ST_TAI_KEEP = 32;

  typedef struct packed {
    logic [ST_CNT_W-1:0]    sent;
    logic [ST_CNT_W-1:0]    rcvd;
    logic [ST_CNT_W-1:0]    lost;
    logic [ST_CNT_W-1:0]    blk;
    logic [ST_LAT_W-1:0]    lat_max;
    logic [ST_LAT_W-1:0]    lat_min;
    logic [31:0]            sum_lo;
    logic [31:0]            sum_hi;
    logic [ST_CNT_W-1:0]    lat_n;
    logic                   ovf;
    logic [ST_CYC_W-1:0]    ts_cyc;
    logic [ST_TAI_KEEP-1:0] ts_tai;
  } stats_t;
endpackage

// File: rtl/sst_event_cnt.sv
module sst_event_cnt #(
  parameter int W        = 32,
  parameter int INC_W    = 1,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_val,
  output logic [W-1:0]     cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W:0] sum_ext;
  assign sum_ext = {1'b0, cnt} + (W+1)'(inc_val);

  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (inc_en) cnt <= sum_ext[W] ? CNT_MAX : sum_ext[W-1:0];
      end
      // R4: a saturating counter never goes down except on clear
      p_sat_mono_r4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (inc_en) cnt <= sum_ext[W-1:0];
      end
    end
  endgenerate

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc_en) |=> $stable(cnt));
endmodule

// File: rtl/sst_lat_track.sv
module sst_lat_track #(
  parameter int LAT_W = 28,
  parameter int SUM_W = 64,
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic [LAT_W-1:0] lat,
  output logic [LAT_W-1:0] lat_max,
  output logic [LAT_W-1:0] lat_min,
  output logic [SUM_W-1:0] sum,
  output logic [NUM_W-1:0] num,
  output logic             ovf
);
  localparam logic [LAT_W-1:0] MIN_INIT = '1;

  logic [SUM_W:0] sum_nxt;
  assign sum_nxt = {1'b0, sum} + (SUM_W+1)'(lat);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lat_max <= '0;
      lat_min <= MIN_INIT;
      sum     <= '0;
      num     <= '0;
      ovf     <= 1'b0;
    end else if (vld) begin
      if (lat > lat_max) lat_max <= lat;
      if (lat < lat_min) lat_min <= lat;
      sum <= sum_nxt[SUM_W-1:0];
      num <= num + 1'b1;
      if (sum_nxt[SUM_W]) ovf <= 1'b1;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lat_max == '0 && lat_min == MIN_INIT && num == '0 && !ovf));
  p_bounds_r5: assert property (@(posedge clk) disable iff (rst)
    (vld && !clr) |=> (lat_max >= $past(lat) && lat_min <= $past(lat)));
  p_count_r6: assert property (@(posedge clk) disable iff (rst)
    (vld && !clr) |=> num == $past(num) + 1'b1);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/sst_freeze.sv
module sst_freeze #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         snap,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);
  logic snap_q;
  logic hold;
  assign hold = snap && snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= 1'b0;
      held   <= RST_VAL;
    end else begin
      snap_q <= snap;
      if (!hold) held <= live;
    end
  end

  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(held));
  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !snap |=> held == $past(live));
endmodule

// File: rtl/stream_stats_top.sv
module stream_stats_top
  import sst_pkg::*;
#(
  parameter int SUM_W = 64,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stat_clr_i,
  input  logic                   seq_clr_i,
  input  logic                   snap_i,
  input  logic                   tx_frame_i,
  input  logic                   rx_frame_i,
  input  logic                   loss_i,
  input  logic [ST_CNT_W-1:0]    loss_num_i,
  input  logic                   blk_loss_i,
  input  logic                   lat_vld_i,
  input  logic [ST_LAT_W-1:0]    lat_i,
  input  logic [ST_TAI_W-1:0]    tai_i,
  input  logic [ST_CYC_W-1:0]    cyc_i,
  output logic [SEQ_W-1:0]       seq_o,
  output logic [ST_CNT_W-1:0]    sent_o,
  output logic [ST_CNT_W-1:0]    rcvd_o,
  output logic [ST_CNT_W-1:0]    lost_o,
  output logic [ST_CNT_W-1:0]    blk_o,
  output logic [ST_LAT_W-1:0]    lat_max_o,
  output logic [ST_LAT_W-1:0]    lat_min_o,
  output logic [31:0]            sum_lo_o,
  output logic [31:0]            sum_hi_o,
  output logic [ST_CNT_W-1:0]    lat_n_o,
  output logic                   sum_ovf_o,
  output logic [ST_CYC_W-1:0]    ts_cyc_o,
  output logic [ST_TAI_KEEP-1:0] ts_tai_o
);
  localparam int HI_W   = SUM_W - 32;
  localparam int ST_W   = $bits(stats_t);
  localparam int N_UNIT = 3;

  localparam stats_t RST_STATS = '{
    sent: '0, rcvd: '0, lost: '0, blk: '0, lat_max: '0,
    lat_min: '1, sum_lo: '0, sum_hi: '0, lat_n: '0, ovf: 1'b0,
    ts_cyc: '0, ts_tai: '0};

  // unit counters: 0 sent, 1 received, 2 block loss
  logic [N_UNIT-1:0]   unit_ev;
  logic [ST_CNT_W-1:0] unit_cnt [N_UNIT];
  assign unit_ev = {blk_loss_i, rx_frame_i, tx_frame_i};

  generate
    for (genvar i = 0; i < N_UNIT; i++) begin : g_unit
      sst_event_cnt #(.W(ST_CNT_W), .INC_W(1), .SATURATE(1'b0)) u_cnt (
        .clk(clk), .rst(rst), .clr(stat_clr_i), .inc_en(unit_ev[i]),
        .inc_val(1'b1), .cnt(unit_cnt[i]));
    end
  endgenerate

  logic [ST_CNT_W-1:0] lost_cnt;
  sst_event_cnt #(.W(ST_CNT_W), .INC_W(ST_CNT_W), .SATURATE(1'b1)) u_lost (
    .clk(clk), .rst(rst), .clr(stat_clr_i), .inc_en(loss_i),
    .inc_val(loss_num_i), .cnt(lost_cnt));

  logic [ST_LAT_W-1:0] lmax, lmin;
  logic [SUM_W-1:0]    lsum;
  logic [ST_CNT_W-1:0] lnum;
  logic                lovf;
  sst_lat_track #(.LAT_W(ST_LAT_W), .SUM_W(SUM_W), .NUM_W(ST_CNT_W)) u_lat (
    .clk(clk), .rst(rst), .clr(stat_clr_i), .vld(lat_vld_i), .lat(lat_i),
    .lat_max(lmax), .lat_min(lmin), .sum(lsum), .num(lnum), .ovf(lovf));

  logic [ST_CYC_W-1:0]    stamp_cyc;
  logic [ST_TAI_KEEP-1:0] stamp_tai;
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_cyc <= '0;
      stamp_tai <= '0;
    end else if (stat_clr_i) begin
      stamp_cyc <= cyc_i;
      stamp_tai <= tai_i[ST_TAI_KEEP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || seq_clr_i) seq_o <= '0;
    else if (tx_frame_i)  seq_o <= seq_o + 1'b1;
  end

  logic [31:0] sum_hi_w;
  always_comb begin
    sum_hi_w = '0;
    sum_hi_w[HI_W-1:0] = lsum[SUM_W-1:32];
  end

  stats_t live, frz;
  always_comb begin
    live.sent    = unit_cnt[0];
    live.rcvd    = unit_cnt[1];
    live.blk     = unit_cnt[2];
    live.lost    = lost_cnt;
    live.lat_max = lmax;
    live.lat_min = lmin;
    live.sum_lo  = lsum[31:0];
    live.sum_hi  = sum_hi_w;
    live.lat_n   = lnum;
    live.ovf     = lovf;
    live.ts_cyc  = stamp_cyc;
    live.ts_tai  = stamp_tai;
  end

  sst_freeze #(.W(ST_W), .RST_VAL(RST_STATS)) u_frz (
    .clk(clk), .rst(rst), .snap(snap_i), .live(live), .held(frz));

  assign sent_o    = frz.sent;
  assign rcvd_o    = frz.rcvd;
  assign lost_o    = frz.lost;
  assign blk_o     = frz.blk;
  assign lat_max_o = frz.lat_max;
  assign lat_min_o = frz.lat_min;
  assign sum_lo_o  = frz.sum_lo;
  assign sum_hi_o  = frz.sum_hi;
  assign lat_n_o   = frz.lat_n;
  assign sum_ovf_o = frz.ovf;
  assign ts_cyc_o  = frz.ts_cyc;
  assign ts_tai_o  = frz.ts_tai;

  p_stamp_r2: assert property (@(posedge clk) disable iff (rst)
    stat_clr_i |=> (stamp_cyc == $past(cyc_i) &&
                    stamp_tai == $past(tai_i[ST_TAI_KEEP-1:0])));
  p_stamp_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !stat_clr_i |=> ($stable(stamp_cyc) && $stable(stamp_tai)));
  p_seq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    seq_clr_i |=> seq_o == '0);
  p_seq_indep_r10: assert property (@(posedge clk) disable iff (rst)
    (!seq_clr_i && !tx_frame_i) |=> $stable(seq_o));
endmodule

// File: tb/sim_stream_stats_top.sv
module sim_stream_stats_top;
  localparam int SUM_W = 36;
  localparam int SEQ_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic stat_clr_i = 0, seq_clr_i = 0, snap_i = 0;
  logic tx_frame_i = 0, rx_frame_i = 0, loss_i = 0, blk_loss_i = 0, lat_vld_i = 0;
  logic [31:0] loss_num_i = '0;
  logic [27:0] lat_i = '0;
  logic [39:0] tai_i = '0;
  logic [27:0] cyc_i = '0;
  logic [SEQ_W-1:0] seq_o;
  logic [31:0] sent_o, rcvd_o, lost_o, blk_o, sum_lo_o, sum_hi_o, lat_n_o, ts_tai_o;
  logic [27:0] lat_max_o, lat_min_o, ts_cyc_o;
  logic sum_ovf_o;

  stream_stats_top #(.SUM_W(SUM_W), .SEQ_W(SEQ_W)) u0 (.*);

  typedef enum int {F_SEQ, F_SENT, F_RCVD, F_LOST, F_BLK, F_MAX, F_MIN,
                    F_LO, F_HI, F_N, F_OVF, F_TSC, F_TST} fld_t;
  typedef struct { fld_t f; logic [63:0] exp; string req; } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [63:0] act(fld_t f);
    case (f)
      F_SEQ:  return 64'(seq_o);
      F_SENT: return 64'(sent_o);
      F_RCVD: return 64'(rcvd_o);
      F_LOST: return 64'(lost_o);
      F_BLK:  return 64'(blk_o);
      F_MAX:  return 64'(lat_max_o);
      F_MIN:  return 64'(lat_min_o);
      F_LO:   return 64'(sum_lo_o);
      F_HI:   return 64'(sum_hi_o);
      F_N:    return 64'(lat_n_o);
      F_OVF:  return 64'(sum_ovf_o);
      F_TSC:  return 64'(ts_cyc_o);
      default: return 64'(ts_tai_o);
    endcase
  endfunction

  // monitor: pops expected items and compares on the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (act(it.f) !== it.exp) begin
        n_fail++;
        $display("FAIL %s field %s: actual %0h expected %0h",
                 it.req, it.f.name(), act(it.f), it.exp);
      end
    end
  end

  // driver helpers
  task automatic push(fld_t f, logic [63:0] e, string r);
    item_t it;
    it.f = f; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // settle: two register stages from input to output, plus margin
  task automatic settle();
    idle(3);
  endtask

  task automatic pulse_tx(int n);
    for (int i = 0; i < n; i++) begin
      tx_frame_i = 1; @(negedge clk); tx_frame_i = 0;
    end
  endtask

  task automatic lat_sample(logic [27:0] v);
    lat_i = v; lat_vld_i = 1; @(negedge clk); lat_vld_i = 0;
  endtask

  task automatic loss_ev(logic [31:0] k);
    loss_num_i = k; loss_i = 1; @(negedge clk); loss_i = 0;
  endtask

  initial begin
    logic [63:0] s;
    idle(3);
    rst = 0;
    settle();
    // R11: reset state
    push(F_SENT, 0, "R11"); push(F_MIN, 64'h0FFFFFFF, "R11");
    push(F_SEQ, 0, "R11"); push(F_OVF, 0, "R11"); push(F_TSC, 0, "R11");
    idle(2);

    // R3 / R10: three sent frames
    pulse_tx(3); settle();
    push(F_SENT, 3, "R3"); push(F_SEQ, 3, "R10");
    idle(2);

    // R3: received and block-loss
    rx_frame_i = 1; idle(2); rx_frame_i = 0;
    blk_loss_i = 1; idle(1); blk_loss_i = 0;
    settle();
    push(F_RCVD, 2, "R3"); push(F_BLK, 1, "R3"); push(F_SENT, 3, "R3");
    idle(2);

    // R4: loss events add their count
    loss_ev(5); loss_ev(7); settle();
    push(F_LOST, 12, "R4");
    idle(2);

    // R5 / R6: latency samples 100, 40, 250
    lat_sample(100); lat_sample(40); lat_sample(250); settle();
    push(F_MAX, 250, "R5"); push(F_MIN, 40, "R5");
    push(F_LO, 390, "R6"); push(F_HI, 0, "R6"); push(F_N, 3, "R6");
    idle(2);

    // R8: snapshot freezes while live counters run
    snap_i = 1; idle(2);
    pulse_tx(4); rx_frame_i = 1; idle(1); rx_frame_i = 0;
    settle();
    push(F_SENT, 3, "R8"); push(F_RCVD, 2, "R8"); push(F_SEQ, 7, "R10");
    idle(2);
    // R9: release shows the live values
    snap_i = 0; settle();
    push(F_SENT, 7, "R9"); push(F_RCVD, 3, "R9");
    idle(2);

    // R10: sequence clear leaves statistics alone
    seq_clr_i = 1; idle(1); seq_clr_i = 0; settle();
    push(F_SEQ, 0, "R10"); push(F_SENT, 7, "R10");
    idle(2);

    // R1 / R2: timestamped statistics clear
    cyc_i = 28'h1234567; tai_i = 40'hAB_CDEF0123;
    pulse_tx(2);
    stat_clr_i = 1; idle(1); stat_clr_i = 0;
    cyc_i = 28'h0000042; tai_i = 40'h0;
    settle();
    push(F_TSC, 64'h1234567, "R2"); push(F_TST, 64'hCDEF0123, "R2");
    push(F_SENT, 0, "R1"); push(F_LOST, 0, "R1"); push(F_MIN, 64'h0FFFFFFF, "R1");
    push(F_MAX, 0, "R1"); push(F_N, 0, "R1"); push(F_SEQ, 2, "R10");
    idle(2);

    // R4: saturation at 0xFFFFFFFF
    loss_ev(32'hFFFF_FFF0); loss_ev(32'h20); settle();
    push(F_LOST, 64'hFFFFFFFF, "R4");
    idle(2);

    // R6: carry into high word (17 samples of max value)
    s = 0;
    for (int i = 0; i < 17; i++) begin lat_sample(28'hFFFFFFF); s += 64'hFFFFFFF; end
    settle();
    push(F_LO, s & 64'hFFFFFFFF, "R6"); push(F_HI, s >> 32, "R6"); push(F_N, 17, "R6");
    idle(2);

    // R7: no overflow at 256 samples, overflow at 257
    for (int i = 17; i < 256; i++) lat_sample(28'hFFFFFFF);
    settle();
    push(F_OVF, 0, "R7"); push(F_N, 256, "R7");
    idle(2);
    lat_sample(28'hFFFFFFF); settle();
    push(F_OVF, 1, "R7"); push(F_LO, 64'h0FFFFEFF, "R7"); push(F_HI, 0, "R7");
    idle(2);
    lat_sample(1); idle(5);
    push(F_OVF, 1, "R7");
    idle(2);
    stat_clr_i = 1; idle(1); stat_clr_i = 0; settle();
    push(F_OVF, 0, "R7"); push(F_TSC, 64'h42, "R2");
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule